// File: doc/BRIEF.md
# Strobe-Addressed FIFO with Read Rewind and Programmable Level Flag

This block is a single-clock first-in first-out buffer for nine-bit words, enough to carry a byte together with a parity bit. It keeps its own write and read positions. Each accepted write strobe stores one word and moves the write position forward. Each accepted read strobe moves the read position forward. No address is supplied from outside.

The block drives three registered flags. The empty flag refuses reads and the full flag refuses writes, so the buffer can neither underflow nor overflow. The level flag rises once the number of stored words reaches a threshold that software-free logic loads through a strobe and value input. After reset that threshold is half the depth.

A rewind input moves the read position back to the first storage location and leaves the write position alone. Words that are still held can then be sent again, for example after a link error. The replay is only meaningful while no more than the depth has been written since reset.

Top module: `rtfifo`

## Requirements
- R1: While reset is high, and on the first cycle after it, empty is 1, full is 0, the level flag is 0, read data is all zeros, and the threshold is depth/2.
- R2: Words leave in the order they were written. Read data changes only on an accepted read, and it shows the word in the cycle after the clock edge that samples the read strobe.
- R3: A write strobe while full is 1 stores nothing, so no held word is overwritten and full stays set unless a read or rewind is accepted in the same cycle.
- R4: A read strobe while empty is 1 leaves read data and the read position unchanged.
- R5: After each clock edge, empty is 1 exactly when occupancy (writes accepted minus read position) is 0, and full is 1 exactly when occupancy equals the depth.
- R6: After each clock edge, the level flag is 1 exactly when occupancy is greater than or equal to the threshold.
- R7: A high thr_load loads thr_value into the threshold, and the level flag after that same edge already uses the new value.
- R8: A read and a write in the same cycle while neither empty nor full are both accepted, and occupancy does not change.
- R9: A high rewind sets the read position to zero without moving the write position. Following reads replay from the first stored word, and occupancy becomes the write position.
- R10: A read strobe in the same cycle as rewind is ignored, and read data holds.
- R11: A read and a write together while empty accept only the write. A read and a write together while full accept only the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered word read out |
| rewind | input | 1 | Return read position to zero |
| thr_load | input | 1 | Load strobe for the threshold |
| thr_value | input | AW+1 | New threshold value |
| empty | output | 1 | No words held |
| full | output | 1 | Depth words held |
| at_level | output | 1 | Occupancy at or above threshold |

## Verification
The bench goes after the edges of occupancy: writing into a full buffer, where a faulty design overwrites the oldest word and the replayed data comes out wrong, and reading an empty one, where a faulty design advances the read position and later produces stale words. It drives simultaneous strobes at empty, at full and in between. A wrong acceptance rule shows up there as drifting flags. It also rewinds, both alone and together with a read, which exposes a design that also clears the write position or still lets the read through. Threshold loads are mixed into random traffic, so an off-by-one in the comparison or a one-cycle lag in applying the new value makes the level flag differ from the model.

// File: rtl/rtfifo_pkg.sv
package rtfifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic at_level;
  } flag_t;
endpackage

// File: rtl/rtfifo_ram.sv
module rtfifo_ram #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rtfifo_ptrs.sv
module rtfifo_ptrs #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rewind,
  input  logic          full,
  input  logic          empty,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   wr_nxt,
  output logic [AW:0]   rd_nxt
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr, rd_ptr;

  // writes refused when full; reads refused when empty or rewinding
  assign wr_go = wr_req & ~full;
  assign rd_go = rd_req & ~empty & ~rewind;

  assign wr_nxt = wr_ptr + {{AW{1'b0}}, wr_go};
  assign rd_nxt = rewind ? '0 : rd_ptr + {{AW{1'b0}}, rd_go};

  assign waddr = wr_ptr[AW-1:0];
  assign raddr = rd_ptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_nxt;
      rd_ptr <= rd_nxt;
    end
  end
endmodule

// File: rtl/rtfifo_flags.sv
module rtfifo_flags
  import rtfifo_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [AW:0] wr_nxt,
  input  logic [AW:0] rd_nxt,
  input  logic        thr_load,
  input  logic [AW:0] thr_value,
  output flag_t       flags
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);
  localparam logic [PW-1:0] THR_RST  = PW'(DEPTH / 2);

  logic [PW-1:0] thr_q, thr_nxt, occ_nxt;

  assign thr_nxt = thr_load ? thr_value : thr_q;
  // extra pointer bit makes the difference span 0..DEPTH
  assign occ_nxt = wr_nxt - rd_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q          <= THR_RST;
      flags.empty    <= 1'b1;
      flags.full     <= 1'b0;
      flags.at_level <= 1'b0;
    end else begin
      thr_q          <= thr_nxt;
      flags.empty    <= (occ_nxt == '0);
      flags.full     <= (occ_nxt == FULL_OCC);
      flags.at_level <= (occ_nxt >= thr_nxt);
    end
  end
endmodule

// File: rtl/rtfifo.sv
module rtfifo
  import rtfifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rewind,
  input  logic          thr_load,
  input  logic [AW:0]   thr_value,
  output logic          empty,
  output logic          full,
  output logic          at_level
);
  flag_t         flags;
  logic          wr_go, rd_go;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wr_nxt, rd_nxt;

  rtfifo_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst),
    .wr_req(wr_en), .rd_req(rd_en), .rewind(rewind),
    .full(flags.full), .empty(flags.empty),
    .wr_go(wr_go), .rd_go(rd_go),
    .waddr(waddr), .raddr(raddr),
    .wr_nxt(wr_nxt), .rd_nxt(rd_nxt)
  );

  rtfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .rst(rst),
    .we(wr_go), .waddr(waddr), .wdata(wr_data),
    .re(rd_go), .raddr(raddr), .rdata(rd_data)
  );

  rtfifo_flags #(.AW(AW)) u_flags (
    .clk(clk), .rst(rst),
    .wr_nxt(wr_nxt), .rd_nxt(rd_nxt),
    .thr_load(thr_load), .thr_value(thr_value),
    .flags(flags)
  );

  assign empty    = flags.empty;
  assign full     = flags.full;
  assign at_level = flags.at_level;
endmodule

// File: rtl/rtfifo_chk.sv
module rtfifo_chk #(
  parameter int DW = 9,
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rewind,
  input logic          thr_load,
  input logic [DW-1:0] rd_data,
  input logic          empty,
  input logic          full,
  input logic          at_level
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (empty && !full && !at_level && rd_data == '0)); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !rewind) |=> full); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en && !rewind) |=> (empty && $stable(rd_data))); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R5

  AST_RW_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!empty && !full && rd_en && wr_en && !rewind && !thr_load)
      |=> (!empty && !full && $stable(at_level))); // R8

  AST_REWIND_NORD: assert property (@(posedge clk) disable iff (rst)
    (rewind && rd_en) |=> $stable(rd_data)); // R10
endmodule

bind rtfifo rtfifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .rewind(rewind), .thr_load(thr_load), .rd_data(rd_data),
  .empty(empty), .full(full), .at_level(at_level)
);

// File: tb/sim_rtfifo.sv
module sim_rtfifo;
  localparam int CLK_P = 10;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0, thr_load = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0]   thr_value = '0;
  logic [DW-1:0] rd_data;
  logic empty, full, at_level;

  int total = 0, bad = 0;
  bit finished = 0;

  // bench model
  logic [DW-1:0] mm [D];
  int wc, rc, thr;
  logic [DW-1:0] exp_rd;

  always #(CLK_P/2) clk = ~clk;

  rtfifo #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rewind(rewind),
    .thr_load(thr_load), .thr_value(thr_value),
    .empty(empty), .full(full), .at_level(at_level)
  );

  function automatic int occ();
    return wc - rc;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R5 empty", int'(empty), int'(occ() == 0));
    chk("R5 full", int'(full), int'(occ() == D));
    chk("R6 level", int'(at_level), int'(occ() >= thr));
    chk("R2 rd_data", int'(rd_data), int'(exp_rd));
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; rd_en = 0; rewind = 0; thr_load = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    wc = 0; rc = 0; thr = D / 2; exp_rd = '0;
    chk("R1 empty", int'(empty), 1);
    chk("R1 full", int'(full), 0);
    chk("R1 level", int'(at_level), 0);
    chk("R1 rd_data", int'(rd_data), 0);
  endtask

  // drive at negedge, model at posedge, sample at next negedge
  task automatic step(bit we, logic [DW-1:0] wd, bit re, bit rw, bit tl, int tv);
    bit wok, rok;
    wr_en = we; wr_data = wd; rd_en = re; rewind = rw;
    thr_load = tl; thr_value = (AW+1)'(tv);
    wok = we && (occ() != D);
    rok = re && (occ() != 0) && !rw;
    @(posedge clk);
    if (rw) rc = 0;
    else if (rok) begin
      exp_rd = mm[rc % D];
      rc++;
    end
    if (wok) begin
      mm[wc % D] = wd;
      wc++;
    end
    if (tl) thr = tv;
    @(negedge clk);
    wr_en = 0; rd_en = 0; rewind = 0; thr_load = 0;
    chk_all();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();                                   // R1

    // R2 / R6: ordered traffic across the default threshold
    for (int i = 0; i < 10; i++) step(1, DW'(9'h100 + i), 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(0, '0, 1, 0, 0, 0);
      chk("R2 order", int'(rd_data), 9'h100 + i);
    end

    // R8: read and write together in the middle
    step(1, 9'h0AA, 1, 0, 0, 0);
    chk("R8 occupancy", occ(), 7);

    // R7: new threshold applies at the loading edge
    step(0, '0, 0, 0, 1, 7);
    chk("R7 level at 7", int'(at_level), 1);
    step(0, '0, 0, 0, 1, 8);
    chk("R7 level at 8", int'(at_level), 0);

    // R3 and R11 at full
    while (occ() < D) step(1, DW'($urandom), 0, 0, 0, 0);
    step(1, 9'h1FF, 0, 0, 0, 0);
    chk("R3 full held", int'(full), 1);
    step(1, 9'h1EE, 1, 0, 0, 0);
    chk("R11 full rd only", occ(), D - 1);
    while (occ() > 0) step(0, '0, 1, 0, 0, 0);

    // R4 and R11 at empty
    held = rd_data;
    step(0, '0, 1, 0, 0, 0);
    chk("R4 rd_data held", int'(rd_data), int'(held));
    step(1, 9'h055, 1, 0, 0, 0);
    chk("R11 empty wr only", occ(), 1);
    chk("R11 rd_data held", int'(rd_data), int'(held));

    // R9 / R10: rewind after a short burst
    do_reset();
    for (int i = 0; i < 5; i++) step(1, DW'(9'h0C0 + i), 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0, 0, 0);
    held = rd_data;
    step(0, '0, 1, 1, 0, 0);
    chk("R10 rd_data held", int'(rd_data), int'(held));
    chk("R9 occupancy", occ(), 5);
    chk("R9 not empty", int'(empty), 0);
    step(0, '0, 1, 0, 0, 0);
    chk("R9 first replay", int'(rd_data), 9'h0C0);

    // R9: rewind from full
    do_reset();
    while (occ() < D) step(1, DW'($urandom), 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0, 0, 0);
    step(0, '0, 0, 1, 0, 0);
    chk("R9 full after rewind", int'(full), 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit we, re, rw, tl;
      if (n % 500 == 499) do_reset();
      we = ($urandom_range(0, 99) < 55);
      re = ($urandom_range(0, 99) < 45);
      rw = (wc <= D) && ($urandom_range(0, 99) < 4);
      tl = ($urandom_range(0, 99) < 3);
      step(we, DW'($urandom), re, rw, tl, $urandom_range(1, D));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule